// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous burst SRAM. It registers its address and control on the rising clock edge and passes read data through to the output in the cycle that follows that edge. Writes use a late-write scheme: the data for a write arrives one active clock after its address. Because of this, reads and writes can follow each other on consecutive clocks with no idle cycle, and one word moves on every active clock. A clock enable freezes the whole pipeline. Three chip enables select the device. Per-lane byte selects qualify each write. A burst input walks through a four-word group in linear or interleaved order.

The shared data bus is split into an input, an output and a drive enable. The drive enable falls during the data phase of every write, so the outputs never fight incoming write data. An output enable gates the drivers asynchronously. A posted-write buffer holds the most recent write until the next write's data arrives. Reads of a posted address are served from that buffer lane by lane.

Top module: `ft_sram_core`

## Requirements
- R1: Synchronous active-high reset clears the pipeline, so that `dq_oe` is 0 afterwards. Reset also clears every word of the array to zero, and reset takes precedence over `clk_en`.
- R2: A read captured at an active edge (chip selected, `wr_n`=1, `burst_next`=0) puts the word at that address on `dq_out` in the cycle right after that edge. `dq_oe`=1 in that cycle if `out_en_n`=0.
- R3: Write data on `dq_in` is captured at the active edge that follows the write's address edge. Only lanes with `byte_sel[b]`=1 are updated, where lane b is bits `b*BYTE_W` to `b*BYTE_W+BYTE_W-1`. Byte selects are sampled with the address, on every beat of a burst.
- R4: Reads and writes may alternate on consecutive active edges. A read of an address whose write is still posted returns the new data for the selected lanes.
- R5: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at a load edge. Otherwise the cycle is a deselect: `dq_oe`=0 in the following data phase and no write takes place.
- R6: An edge with `clk_en`=0 is ignored. All state holds, including a pending write data phase, and `dq_out` stays unchanged.
- R7: `out_en_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge.
- R8: `dq_oe` is 0 during the data phase of every write, both a loaded write and a burst continuation of one.
- R9: `burst_next`=1 at an active edge continues the previous operation type. The chip enables and `wr_n` are ignored on that edge. In linear order the low two address bits become (start + n) mod 4, and the upper bits stay fixed.
- R10: With `burst_ilv`=1 at the load edge, the low two bits follow start XOR n. The order is fixed at the load edge and does not change during the burst. The count wraps after four beats.
- R11: A burst continuation after a deselect stays deselected, so `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; 0 makes the edge a no-op |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write, 1 = read at a load edge |
| burst_next | input | 1 | 1 = advance the burst instead of loading |
| burst_ilv | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| byte_sel | input | N_BYTES | Per-lane write qualifiers, active high |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | N_BYTES*BYTE_W | Write data from the bus |
| dq_out | output | N_BYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The checker checks four behaviours on every clock:
- `dq_oe` is low whenever the output enable is released.
- The drivers are off after each write load and each deselect.
- The drivers are on after a read load with the output enable asserted.
- `dq_out` holds across a stalled edge.

Some behaviours only the bench's scenarios can show. These are the data contents: lane-masked writes, merges from the posted buffer against committed data, and the linear and interleaved burst address sequences with their wrap. A write whose data phase is stretched by a stall, and the proof that deselected writes leave memory unchanged, are also checked by the bench alone.

// File: rtl/ftsr_pkg.sv
package ftsr_pkg;

    // Bits of the address walked by a burst.
    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits for beat n of a burst from start.
    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input logic                  ilv
    );
        if (ilv)
            return start ^ beat;
        else
            return start + beat;
    endfunction

    // Three-way chip-enable decode.
    function automatic logic chip_sel(
        input logic en1_n,
        input logic en2,
        input logic en3_n
    );
        return !en1_n && en2 && !en3_n;
    endfunction

endpackage

// File: rtl/ftsr_cmd_reg.sv
module ftsr_cmd_reg
    import ftsr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int N_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_en,
    input  logic               cs1_n,
    input  logic               cs2,
    input  logic               cs3_n,
    input  logic               wr_n,
    input  logic               burst_next,
    input  logic               burst_ilv,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_BYTES-1:0] byte_sel,
    output op_e                op_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [N_BYTES-1:0] bytes_o
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        op_e                   op;
        logic [HI_W-1:0]       hi;
        logic [BURST_BITS-1:0] start;
        logic [BURST_BITS-1:0] beat;
        logic                  ilv;
        logic [N_BYTES-1:0]    bytes;
    } cmd_t;

    cmd_t cur;
    cmd_t nxt;

    always_comb begin
        nxt       = cur;
        nxt.bytes = byte_sel;
        if (burst_next) begin
            nxt.beat = cur.beat + 1'b1;
        end else begin
            nxt.beat  = '0;
            nxt.hi    = addr[ADDR_W-1:BURST_BITS];
            nxt.start = addr[BURST_BITS-1:0];
            nxt.ilv   = burst_ilv;
            if (!chip_sel(cs1_n, cs2, cs3_n))
                nxt.op = OP_IDLE;
            else if (wr_n)
                nxt.op = OP_READ;
            else
                nxt.op = OP_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.op    <= OP_IDLE;
            cur.hi    <= '0;
            cur.start <= '0;
            cur.beat  <= '0;
            cur.ilv   <= 1'b0;
            cur.bytes <= '0;
        end else if (clk_en) begin
            cur <= nxt;
        end
    end

    assign op_o    = cur.op;
    assign addr_o  = {cur.hi, burst_low(cur.start, cur.beat, cur.ilv)};
    assign bytes_o = cur.bytes;

endmodule

// File: rtl/ftsr_array.sv
module ftsr_array #(
    parameter int ADDR_W  = 4,
    parameter int BYTE_W  = 9,
    parameter int N_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [N_BYTES*BYTE_W-1:0]   wdata,
    input  logic [N_BYTES-1:0]          wbe,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [N_BYTES*BYTE_W-1:0]   rdata
);

    localparam int DATA_W = N_BYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            for (int b = 0; b < N_BYTES; b++)
                if (wbe[b])
                    mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ftsr_post_buf.sv
module ftsr_post_buf #(
    parameter int ADDR_W  = 4,
    parameter int BYTE_W  = 9,
    parameter int N_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clk_en,
    input  logic                        cap,
    input  logic [ADDR_W-1:0]           cap_addr,
    input  logic [N_BYTES-1:0]          cap_bytes,
    input  logic [N_BYTES*BYTE_W-1:0]   cap_data,
    output logic                        cm_we,
    output logic [ADDR_W-1:0]           cm_addr,
    output logic [N_BYTES*BYTE_W-1:0]   cm_data,
    output logic [N_BYTES-1:0]          cm_be,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [N_BYTES*BYTE_W-1:0]   arr_data,
    output logic [N_BYTES*BYTE_W-1:0]   merged
);

    localparam int DATA_W = N_BYTES * BYTE_W;

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  addr;
        logic [N_BYTES-1:0] bytes;
        logic [DATA_W-1:0]  data;
    } post_t;

    post_t pb;

    always_ff @(posedge clk) begin
        if (rst) begin
            pb.valid <= 1'b0;
            pb.addr  <= '0;
            pb.bytes <= '0;
            pb.data  <= '0;
        end else if (clk_en && cap) begin
            pb.valid <= 1'b1;
            pb.addr  <= cap_addr;
            pb.bytes <= cap_bytes;
            pb.data  <= cap_data;
        end
    end

    // The older posted word retires as the newer one is captured.
    assign cm_we   = clk_en && cap && pb.valid;
    assign cm_addr = pb.addr;
    assign cm_data = pb.data;
    assign cm_be   = pb.bytes;

    logic addr_hit;
    assign addr_hit = pb.valid && (pb.addr == rd_addr);

    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        assign merged[b*BYTE_W +: BYTE_W] = (addr_hit && pb.bytes[b])
                                          ? pb.data[b*BYTE_W +: BYTE_W]
                                          : arr_data[b*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/ft_sram_core.sv
module ft_sram_core
    import ftsr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BYTE_W  = 9,
    parameter int N_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clk_en,
    input  logic                        cs1_n,
    input  logic                        cs2,
    input  logic                        cs3_n,
    input  logic                        wr_n,
    input  logic                        burst_next,
    input  logic                        burst_ilv,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [N_BYTES-1:0]          byte_sel,
    input  logic                        out_en_n,
    input  logic [N_BYTES*BYTE_W-1:0]   dq_in,
    output logic [N_BYTES*BYTE_W-1:0]   dq_out,
    output logic                        dq_oe
);

    localparam int DATA_W = N_BYTES * BYTE_W;

    op_e                op;
    logic [ADDR_W-1:0]  cur_addr;
    logic [N_BYTES-1:0] cur_bytes;

    logic               cm_we;
    logic [ADDR_W-1:0]  cm_addr;
    logic [DATA_W-1:0]  cm_data;
    logic [N_BYTES-1:0] cm_be;
    logic [DATA_W-1:0]  arr_data;

    ftsr_cmd_reg #(
        .ADDR_W  (ADDR_W),
        .N_BYTES (N_BYTES)
    ) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .wr_n       (wr_n),
        .burst_next (burst_next),
        .burst_ilv  (burst_ilv),
        .addr       (addr),
        .byte_sel   (byte_sel),
        .op_o       (op),
        .addr_o     (cur_addr),
        .bytes_o    (cur_bytes)
    );

    ftsr_post_buf #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .N_BYTES (N_BYTES)
    ) u_post (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .cap       (op == OP_WRITE),
        .cap_addr  (cur_addr),
        .cap_bytes (cur_bytes),
        .cap_data  (dq_in),
        .cm_we     (cm_we),
        .cm_addr   (cm_addr),
        .cm_data   (cm_data),
        .cm_be     (cm_be),
        .rd_addr   (cur_addr),
        .arr_data  (arr_data),
        .merged    (dq_out)
    );

    ftsr_array #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .N_BYTES (N_BYTES)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (cm_data),
        .wbe   (cm_be),
        .raddr (cur_addr),
        .rdata (arr_data)
    );

    // Drivers on only in a read data phase with the output enable asserted.
    assign dq_oe = (op == OP_READ) && !out_en_n;

endmodule

// File: rtl/ft_sram_core_chk.sv
module ft_sram_core_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en,
    input logic          cs1_n,
    input logic          cs2,
    input logic          cs3_n,
    input logic          wr_n,
    input logic          burst_next,
    input logic          out_en_n,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);

    logic sel;
    assign sel = !cs1_n && cs2 && !cs3_n;

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dq_oe);

    // R8
    write_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && clk_en && !burst_next && sel && !wr_n) |-> !dq_oe);

    // R5
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && clk_en && !burst_next && !sel) |-> !dq_oe);

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && clk_en && !burst_next && sel && wr_n) && !out_en_n) |-> dq_oe);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(dq_out));

endmodule

bind ft_sram_core ft_sram_core_chk #(.DW(N_BYTES*BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .wr_n       (wr_n),
    .burst_next (burst_next),
    .out_en_n   (out_en_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
);

// File: tb/tb_ft_sram_core.sv
module tb_ft_sram_core;

    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int BW    = 9;
    localparam int NB    = 4;
    localparam int DW    = BW * NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b1;
    logic          cs1_n = 1'b1;
    logic          cs2 = 1'b0;
    logic          cs3_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          burst_next = 1'b0;
    logic          burst_ilv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] byte_sel = '0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ft_sram_core #(.ADDR_W(AW), .BYTE_W(BW), .N_BYTES(NB)) dut (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .wr_n       (wr_n),
        .burst_next (burst_next),
        .burst_ilv  (burst_ilv),
        .addr       (addr),
        .byte_sel   (byte_sel),
        .out_en_n   (out_en_n),
        .dq_in      (dq_in),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    typedef struct packed {
        logic          ce;
        logic          c1n;
        logic          c2;
        logic          c3n;
        logic          wrn;
        logic          bn;
        logic          ilv;
        logic [3:0]    a;
        logic [3:0]    bs;
        logic [35:0]   din;
        logic          oen;
        logic          ck_oe;
        logic          exp_oe;
        logic          ck_dq;
        logic [35:0]   exp_dq;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        // R8: write load A1, its data phase is quiet
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd1,4'hF,36'h0,        1'b0,1'b1,1'b0,1'b0,36'h0,        8'd8},
        // R3: write load A2, data for A1 on the bus
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,4'hF,36'h111111111,1'b0,1'b1,1'b0,1'b0,36'h0,        8'd3},
        // R2: read A1 right after a write (data for A2 on the bus)
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd1,4'hF,36'h222222222,1'b0,1'b1,1'b1,1'b1,36'h111111111,8'd2},
        // R4: read A2 while its write is still posted
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd2,4'hF,36'h0,        1'b0,1'b1,1'b1,1'b1,36'h222222222,8'd4},
        // R4: read then write back to back
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3,4'hF,36'h0,        1'b0,1'b1,1'b0,1'b0,36'h0,        8'd4},
        // R4: write then read of the same word
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3,4'hF,36'h333333333,1'b0,1'b1,1'b1,1'b1,36'h333333333,8'd4},
        // R6: stalled edge with a write request, output holds
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd5,4'hF,36'h0ABCDEF01,1'b0,1'b1,1'b1,1'b1,36'h333333333,8'd6},
        // R5: cs2 low deselects
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3,4'hF,36'h0,        1'b0,1'b1,1'b0,1'b0,36'h0,        8'd5},
        // R7: read with output enable released
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3,4'hF,36'h0,        1'b1,1'b1,1'b0,1'b0,36'h0,        8'd7},
        // R1: never-written word reads zero
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd0,4'hF,36'h0,        1'b0,1'b1,1'b1,1'b1,36'h0,        8'd1},
        // R5: cs1_n high deselects
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'd1,4'hF,36'h0,        1'b0,1'b1,1'b0,1'b0,36'h0,        8'd5},
        // R5: cs3_n high deselects
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,4'd1,4'hF,36'h0,        1'b0,1'b1,1'b0,1'b0,36'h0,        8'd5},
        // R5: deselected write request to A0
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,4'hF,36'h0,        1'b0,1'b1,1'b0,1'b0,36'h0,        8'd5},
        // R5: A0 still zero, data on the bus was not written
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd0,4'hF,36'hFFFFFFFFF,1'b0,1'b1,1'b1,1'b1,36'h0,        8'd5}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ce, input logic c1n, input logic c2, input logic c3n,
                       input logic wrn, input logic bn, input logic ilv,
                       input logic [AW-1:0] a, input logic [NB-1:0] bs,
                       input logic [DW-1:0] din, input logic oen);
        @(negedge clk);
        clk_en = ce; cs1_n = c1n; cs2 = c2; cs3_n = c3n; wr_n = wrn;
        burst_next = bn; burst_ilv = ilv; addr = a; byte_sel = bs;
        dq_in = din; out_en_n = oen;
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] din);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 4'hF, din, 1'b0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bs, input logic [DW-1:0] din);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, a, bs, din, 1'b0);
    endtask

    // Advance a burst with the select inputs set to a deselect-write pattern.
    task automatic adv(input logic [DW-1:0] din);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 4'hF, din, 1'b0);
    endtask

    function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] bs);
        logic [DW-1:0] r;
        r = old_w;
        for (int b = 0; b < NB; b++)
            if (bs[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
        return r;
    endfunction

    localparam logic [DW-1:0] W1 = 36'h123456789;
    localparam logic [DW-1:0] W2 = 36'h987654321;
    localparam logic [DW-1:0] D0 = 36'hA00000001;
    localparam logic [DW-1:0] D1 = 36'hB00000002;
    localparam logic [DW-1:0] D2 = 36'hC00000003;
    localparam logic [DW-1:0] D3 = 36'hD00000004;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #(CLK_P/4);
        // R1: drivers off after reset
        chk("R1 oe after reset", {35'd0, dq_oe}, 36'd0);
        rd(4'd5, '0);
        chk("R1 cleared word", dq_out, 36'd0);

        for (int i = 0; i < NV; i++) begin
            cyc(VT[i].ce, VT[i].c1n, VT[i].c2, VT[i].c3n, VT[i].wrn, VT[i].bn,
                VT[i].ilv, VT[i].a, VT[i].bs, VT[i].din, VT[i].oen);
            if (VT[i].ck_oe)
                chk($sformatf("R%0d vec %0d oe", VT[i].req, i), {35'd0, dq_oe}, {35'd0, VT[i].exp_oe});
            if (VT[i].ck_dq)
                chk($sformatf("R%0d vec %0d data", VT[i].req, i), dq_out, VT[i].exp_dq);
        end

        // R3: partial lane write over a full word, seen via the posted path
        wr(4'd4, 4'hF, '0);
        wr(4'd4, 4'b0101, W1);
        rd(4'd4, W2);
        chk("R3 lane merge posted", dq_out, lane_mix(W1, W2, 4'b0101));
        wr(4'd9, 4'hF, '0);
        rd(4'd4, 36'h0);
        chk("R3 lane merge committed", dq_out, lane_mix(W1, W2, 4'b0101));

        // R6: a stall stretches a write data phase
        wr(4'd8, 4'hF, '0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 4'hF, 36'h555555555, 1'b0);
        chk("R6 write phase held", {35'd0, dq_oe}, 36'd0);
        rd(4'd8, 36'h0CAFE0123);
        chk("R6 data after stall", dq_out, 36'h0CAFE0123);

        // R9: linear write burst from A6, selects ignored while advancing
        wr(4'd6, 4'hF, '0);
        adv(D0);
        chk("R8 burst write phase", {35'd0, dq_oe}, 36'd0);
        adv(D1);
        adv(D2);
        rd(4'd5, D3);
        chk("R9 linear beat A5", dq_out, D3);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'hF, '0, 1'b0);
        chk("R9 linear read A6", dq_out, D0);
        adv('0);
        chk("R9 linear read A7 oe", {35'd0, dq_oe}, 36'd1);
        chk("R9 linear read A7", dq_out, D1);
        adv('0);
        chk("R9 wrap to A4", dq_out, D2);

        // R10: interleaved read burst from A5: 5,4,7,6 then wrap to 5
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5, 4'hF, '0, 1'b0);
        chk("R10 ilv beat0", dq_out, D3);
        adv('0);
        chk("R10 ilv beat1", dq_out, D2);
        adv('0);
        chk("R10 ilv beat2", dq_out, D1);
        adv('0);
        chk("R10 ilv beat3", dq_out, D0);
        adv('0);
        chk("R10 ilv wrap", dq_out, D3);

        // R7: output enable acts between edges
        rd(4'd1, '0);
        chk("R7 oe on", {35'd0, dq_oe}, 36'd1);
        out_en_n = 1'b1;
        #1;
        chk("R7 oe released", {35'd0, dq_oe}, 36'd0);
        out_en_n = 1'b0;
        #1;
        chk("R7 oe restored", {35'd0, dq_oe}, 36'd1);

        // R11: advancing after a deselect stays off
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 4'hF, '0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 4'hF, '0, 1'b0);
        chk("R11 advance after deselect", {35'd0, dq_oe}, 36'd0);

        // R1: reset wins over a low clock enable
        @(negedge clk);
        rst = 1'b1;
        clk_en = 1'b0;
        @(posedge clk);
        #(CLK_P/4);
        @(negedge clk);
        rst = 1'b0;
        clk_en = 1'b1;
        rd(4'd1, '0);
        chk("R1 array cleared", dq_out, 36'd0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule